// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flag

This block is the integer execute stage of a small processor core. Each cycle it takes an operation code, two 32-bit register operands and a raw 16-bit immediate field. It returns a 32-bit result with a write enable for the register file, plus the next value of a single condition flag with its own write enable. The datapath is purely combinational. The condition flag lives in a one-bit register inside the block and changes on the rising clock edge.

The one flag does several jobs. It supplies the carry-in of add-with-carry and takes its carry-out. It records signed overflow for the checked adds. It holds the less-than outcome of every compare. It follows bit 0 of the status word produced by the status-clear operation. Immediates are widened in three ways: a 16-bit sign extension, an 8-bit sign extension and a 16-bit zero extension.

The operand roles are fixed. `opa_i` is the destination, the first compare operand or the status word. `opb_i` is the source register. The three-operand immediate forms use `opb_i` as their base.

Top module: `ialu_cflag`

## Requirements
- R1: Operation codes on `op_i` are 0 no-op, 1 add reg, 2 add imm16, 3 add imm8, 4 checked add reg, 5 checked add imm16, 6 add with carry, 7 and reg, 8 and imm16, 9 signed compare reg, 10 signed compare imm, 11 unsigned compare reg, 12 unsigned compare imm, 13 status clear. After reset the condition flag `cflag_o` reads 0.
- R2: Add reg (1) returns `opa_i + opb_i` with `res_we_o` high and leaves the flag unchanged (`cflag_we_o` low).
- R3: Add imm16 (2) returns `opb_i` plus `imm_i` sign-extended from bit 15. Add imm8 (3) returns `opa_i` plus `imm_i[7:0]` sign-extended from bit 7. Neither writes the flag.
- R4: Checked adds (4: `opa_i + opb_i`; 5: `opb_i` + sign-extended imm16) write the wrapped sum and set the flag to 1 exactly on two's-complement signed overflow.
- R5: Add with carry (6) returns `opa_i + opb_i + cflag_o` and writes the carry out of bit 31 to the flag.
- R6: And reg (7) returns `opa_i & opb_i`. And imm16 (8) returns `opb_i` ANDed with `imm_i` zero-extended.
- R7: Signed compares (9: against `opb_i`; 10: against sign-extended imm16) set the flag to `opa_i < operand` taken as signed, and keep `res_we_o` low.
- R8: Unsigned compares (11: against `opb_i`; 12: against `imm_i` sign-extended, then read as unsigned) set the flag to the unsigned less-than, and keep `res_we_o` low.
- R9: Status clear (13) returns `opa_i` with each bit of `opa_i[7:0]` cleared where `imm_i[7:0]` is 1, keeps bits 31:8 unchanged, writes the result, and loads the flag from result bit 0.
- R10: Codes 0, 14 and 15 raise neither `res_we_o` nor `cflag_we_o`, and the flag holds its value.
- R11: `cflag_o` takes `cflag_next_o` on a rising edge only when `cflag_we_o` is high. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | Destination, first operand or status word |
| opb_i | input | 32 | Source operand |
| imm_i | input | 16 | Raw immediate field |
| result_o | output | 32 | Result value |
| res_we_o | output | 1 | Result write enable |
| cflag_o | output | 1 | Current condition flag |
| cflag_next_o | output | 1 | Next condition flag |
| cflag_we_o | output | 1 | Condition flag write enable |

## Verification
The bench targets the overflow edges of the checked adds: 0x7FFFFFFF + 1 and 0x80000000 + 0x80000000. A design that tested carry instead of sign overflow would flag the wrong one. It drives add-with-carry with an all-ones operand and the flag set, so that a dropped carry-in or a missing carry-out shows up as a wrong zero result or a clear flag. The immediate forms get top-bit-set immediates (0x8000, 0x0080, 0xFFFF). A wrong extension would turn a large unsigned compare bound into a small one, or leak sign bits through the AND. The bench also checks that compares and unused codes leave the result enable low and the flag untouched.

// File: rtl/ialu_pkg.sv
`timescale 1ns/1ps
package ialu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int SIMM_W = 8;
  localparam int STAT_W = 8;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP       = 4'd0,
    OP_ADD_RR    = 4'd1,
    OP_ADD_RI16  = 4'd2,
    OP_ADD_RI8   = 4'd3,
    OP_ADDOV_RR  = 4'd4,
    OP_ADDOV_RI  = 4'd5,
    OP_ADDC_RR   = 4'd6,
    OP_AND_RR    = 4'd7,
    OP_AND_RI    = 4'd8,
    OP_CMPS_RR   = 4'd9,
    OP_CMPS_RI   = 4'd10,
    OP_CMPU_RR   = 4'd11,
    OP_CMPU_RI   = 4'd12,
    OP_STAT_CLR  = 4'd13
  } alu_op_e;
endpackage

// File: rtl/ialu_imm_ext.sv
`timescale 1ns/1ps
module ialu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 8
) (
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] sx_long_o,
  output logic [DATA_W-1:0] zx_long_o,
  output logic [DATA_W-1:0] sx_short_o
);
  localparam int PAD_L = DATA_W - IMM_W;
  localparam int PAD_S = DATA_W - SIMM_W;

  always_comb begin
    sx_long_o  = {{PAD_L{imm_i[IMM_W-1]}}, imm_i};
    zx_long_o  = {{PAD_L{1'b0}}, imm_i};
    sx_short_o = {{PAD_S{imm_i[SIMM_W-1]}}, imm_i[SIMM_W-1:0]};
  end
endmodule

// File: rtl/ialu_adder.sv
`timescale 1ns/1ps
module ialu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] wide;

  always_comb begin
    wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    // signed overflow: like-signed inputs, differently signed sum
    ovf_o  = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
  end

  // R4/R5: a carry out means the sum wrapped to at most the first operand
  always_comb begin
    a_r5_carry_wraps: assert (!cout_o || (sum_o <= a_i));
  end
endmodule

// File: rtl/ialu_cmp.sv
`timescale 1ns/1ps
module ialu_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  always_comb begin
    lt_s_o = $signed(a_i) < $signed(b_i);
    lt_u_o = a_i < b_i;
  end

  // R7/R8: with equal sign bits the signed and unsigned orders agree
  always_comb begin
    a_r8_sign_agree: assert ((a_i[W-1] != b_i[W-1]) || (lt_s_o == lt_u_o));
  end
endmodule

// File: rtl/ialu_rst_sync.sv
`timescale 1ns/1ps
module ialu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ialu_cflag.sv
`timescale 1ns/1ps
module ialu_cflag
  import ialu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              res_we_o,
  output logic              cflag_o,
  output logic              cflag_next_o,
  output logic              cflag_we_o
);
  localparam int UPPER_W = DATA_W - STAT_W;

  alu_op_e           op;
  logic              rst_sync_n;
  logic [DATA_W-1:0] sx_long, zx_long, sx_short;
  logic [DATA_W-1:0] add_a, add_b, add_sum, cmp_b, clr_res;
  logic              add_cin, add_cout, add_ovf, lt_s, lt_u;
  logic              cflag_q;

  assign op = alu_op_e'(op_i);

  ialu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ialu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SIMM_W(SIMM_W)) u_ext (
    .imm_i(imm_i), .sx_long_o(sx_long), .zx_long_o(zx_long), .sx_short_o(sx_short)
  );

  // operand selection for the shared adder and comparator
  always_comb begin
    add_a   = opa_i;
    add_b   = opb_i;
    add_cin = 1'b0;
    cmp_b   = opb_i;
    case (op)
      OP_ADD_RI16, OP_ADDOV_RI: begin add_a = opb_i; add_b = sx_long; end
      OP_ADD_RI8:               add_b = sx_short;
      OP_ADDC_RR:               add_cin = cflag_q;
      OP_CMPS_RI, OP_CMPU_RI:   cmp_b = sx_long;
      default: ;
    endcase
  end

  ialu_adder #(.W(DATA_W)) u_add (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  ialu_cmp #(.W(DATA_W)) u_cmp (
    .a_i(opa_i), .b_i(cmp_b), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  assign clr_res = {opa_i[DATA_W-1:STAT_W], opa_i[STAT_W-1:0] & ~imm_i[STAT_W-1:0]};

  // result and flag selection
  always_comb begin
    result_o     = '0;
    res_we_o     = 1'b0;
    cflag_next_o = cflag_q;
    cflag_we_o   = 1'b0;
    case (op)
      OP_ADD_RR, OP_ADD_RI16, OP_ADD_RI8: begin
        result_o = add_sum; res_we_o = 1'b1;
      end
      OP_ADDOV_RR, OP_ADDOV_RI: begin
        result_o = add_sum; res_we_o = 1'b1;
        cflag_next_o = add_ovf; cflag_we_o = 1'b1;
      end
      OP_ADDC_RR: begin
        result_o = add_sum; res_we_o = 1'b1;
        cflag_next_o = add_cout; cflag_we_o = 1'b1;
      end
      OP_AND_RR: begin result_o = opa_i & opb_i;   res_we_o = 1'b1; end
      OP_AND_RI: begin result_o = opb_i & zx_long; res_we_o = 1'b1; end
      OP_CMPS_RR, OP_CMPS_RI: begin cflag_next_o = lt_s; cflag_we_o = 1'b1; end
      OP_CMPU_RR, OP_CMPU_RI: begin cflag_next_o = lt_u; cflag_we_o = 1'b1; end
      OP_STAT_CLR: begin
        result_o = clr_res; res_we_o = 1'b1;
        cflag_next_o = clr_res[0]; cflag_we_o = 1'b1;
      end
      default: ;
    endcase
  end

  // flag register with explicit enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     cflag_q <= 1'b0;
    else if (cflag_we_o) cflag_q <= cflag_next_o;
  end

  assign cflag_o = cflag_q;

  // R11: hold when not enabled, load the offered value when enabled
  a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cflag_we_o |=> $stable(cflag_o));
  a_r11_flag_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cflag_we_o |=> (cflag_o == $past(cflag_next_o)));
  // R4: a flagged overflow on the register form flips the sign of opa
  a_r4_ovf_sign: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_ADDOV_RR && cflag_next_o) |-> (result_o[DATA_W-1] != opa_i[DATA_W-1]));
  // R8: equal operands are never unsigned-less
  a_r8_equal_not_less: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_CMPU_RR && opa_i == opb_i) |-> !cflag_next_o);
  // R9: status clear keeps the upper bits
  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_STAT_CLR) |-> (result_o[DATA_W-1 -: UPPER_W] == opa_i[DATA_W-1 -: UPPER_W]));
endmodule

// File: tb/ialu_cflag_test.sv
`timescale 1ns/1ps
module ialu_cflag_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic [15:0] imm;
  logic [31:0] result;
  logic        res_we, cflag, cflag_next, cflag_we;

  int checks = 0;
  int fails  = 0;
  bit exp_c  = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ialu_cflag uut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(opa), .opb_i(opb), .imm_i(imm),
    .result_o(result), .res_we_o(res_we), .cflag_o(cflag),
    .cflag_next_o(cflag_next), .cflag_we_o(cflag_we)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9, 4'd10: return "R7";
      4'd11, 4'd12: return "R8";
      4'd13: return "R9";
      default: return "R10";
    endcase
  endfunction

  // returns {res_we, result, flag_we, flag_next}
  function automatic logic [34:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] i,
                                        input bit c);
    logic [31:0] s16, s8, r;
    logic [32:0] w;
    logic        we, fwe, fn;
    s16 = {{16{i[15]}}, i};
    s8  = {{24{i[7]}}, i[7:0]};
    r = '0; we = 0; fwe = 0; fn = c;
    case (o)
      4'd1: begin r = a + b;   we = 1; end
      4'd2: begin r = b + s16; we = 1; end
      4'd3: begin r = a + s8;  we = 1; end
      4'd4, 4'd5: begin
        logic [31:0] y;
        y = (o == 4'd4) ? a : b;
        w = {y[31], y} + ((o == 4'd4) ? {b[31], b} : {s16[31], s16});
        r = w[31:0]; we = 1; fwe = 1; fn = w[32] ^ w[31];
      end
      4'd6: begin w = {1'b0, a} + {1'b0, b} + 33'(c); r = w[31:0]; we = 1; fwe = 1; fn = w[32]; end
      4'd7: begin r = a & b; we = 1; end
      4'd8: begin r = b & {16'h0, i}; we = 1; end
      4'd9:  begin fwe = 1; fn = $signed(a) < $signed(b); end
      4'd10: begin fwe = 1; fn = $signed(a) < $signed(s16); end
      4'd11: begin fwe = 1; fn = a < b; end
      4'd12: begin fwe = 1; fn = a < s16; end
      4'd13: begin r = a & ~{24'h0, i[7:0]}; we = 1; fwe = 1; fn = r[0]; end
      default: ;
    endcase
    return {we, r, fwe, fn};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i);
    logic [34:0] m;
    string rq;
    @(negedge clk);
    op = o; opa = a; opb = b; imm = i;
    #1;
    m  = model(o, a, b, i, exp_c);
    rq = req_of(o);
    chk("R11", "flag", 32'(cflag), 32'(exp_c));
    chk(rq, "res_we", 32'(res_we), 32'(m[34]));
    if (m[34]) chk(rq, "result", result, m[33:2]);
    chk(rq, "flag_we", 32'(cflag_we), 32'(m[1]));
    chk(rq, "flag_next", 32'(cflag_next), 32'(m[0]));
    @(posedge clk);
    if (m[1]) exp_c = m[0];
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; op = '0; opa = '0; opb = '0; imm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset flag", 32'(cflag), 32'h0);

    // directed corners
    do_op(4'd4, 32'h7FFF_FFFF, 32'h1, 16'h0);          // R4 positive overflow
    do_op(4'd4, 32'h8000_0000, 32'h8000_0000, 16'h0);  // R4 negative overflow, sum 0
    do_op(4'd4, 32'hFFFF_FFFF, 32'h1, 16'h0);          // R4 carry but no overflow
    do_op(4'd5, 32'h0, 32'h7FFF_FFFF, 16'h0001);       // R4 imm form overflow
    do_op(4'd11, 32'h0, 32'h1, 16'h0);                 // R8 set flag
    do_op(4'd6, 32'hFFFF_FFFF, 32'h0, 16'h0);          // R5 carry in wraps
    do_op(4'd6, 32'h1, 32'h2, 16'h0);                  // R5 carry in, no carry out
    do_op(4'd12, 32'h1, 32'h0, 16'hFFFF);              // R8 imm becomes 0xFFFFFFFF
    do_op(4'd10, 32'h0, 32'h0, 16'hFFFF);              // R7 0 < -1 false
    do_op(4'd9, 32'hFFFF_FFFF, 32'h1, 16'h0);          // R7 -1 < 1 true
    do_op(4'd1, 32'h5, 32'h6, 16'h0);                  // R2 flag unchanged
    do_op(4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h8000); // R6 zero extension
    do_op(4'd3, 32'h100, 32'h0, 16'hFF80);             // R3 imm8 = -128
    do_op(4'd2, 32'h0, 32'h10, 16'h8000);              // R3 imm16 negative
    do_op(4'd13, 32'hABCD_12FF, 32'h0, 16'hFF0E);      // R9 clear mask, bit0 kept
    do_op(4'd14, 32'h1, 32'h2, 16'h3);                 // R10 unused code
    do_op(4'd0, 32'h1, 32'h2, 16'h3);                  // R10 no-op
    do_op(4'd13, 32'h0000_0001, 32'h0, 16'h0001);      // R9 clears flag
    do_op(4'd15, 32'hFFFF_FFFF, 32'h1, 16'h0);         // R10 unused code

    // constrained random
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (($urandom % 8) == 0) b = a;
      if (($urandom % 8) == 0) a = {a[31], {31{~a[31]}}};
      do_op(4'($urandom % 16), a, b, 16'($urandom));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule